// File: doc/BRIEF.md
# Dithered Counter-Compare Pulse-Width Modulator

This block produces the gate pulse for a switching converter from a digital duty command. A free-running counter of `CNT_W` bits defines a switching period of `2^CNT_W` clocks, and the gate is high from the first clock of each period until the counter reaches the coarse on-time. The coarse on-time comes from the upper `CNT_W` bits of the duty command.

The lowest `DITH_W` bits of the command form a fraction. Over a dither frame of `2^DITH_W` consecutive periods, exactly that many periods are stretched by one clock. The stretched periods are spread evenly through the frame instead of being grouped together. The average duty therefore resolves `DITH_W` bits finer than the counter alone, without a faster clock. The frame length is fixed at `2^DITH_W`, so the dither ripple sits at one known subharmonic of the switching frequency.

The duty command is captured only at frame boundaries, so each frame runs with one value from start to end. Two strobes mark period starts and frame starts, which lets a sampling ADC and the compensator align to the modulator.

Top module: `dpwm_dither`

## Requirements
- R1: `period_start_o` is high for exactly one clock in every `2^CNT_W` clocks, on the first clock of each switching period.
- R2: `frame_start_o` is high only together with `period_start_o`, on the first period of every group of `2^DITH_W` periods.
- R3: Let C be the coarse on-time and E be 1 in an extended period and 0 otherwise. When C is not all ones, the gate is high for the first C+E clocks of the period and low for the rest.
- R4: Number the periods of a frame from 0. Period p is extended when the bit-reversed value of p, taken over `DITH_W` bits, is less than the fraction. With `DITH_W`=2 this gives: fraction 1 extends {0}, fraction 2 extends {0,2}, and fraction 3 extends {0,1,2}.
- R5: The duty command is split into two fields. The coarse on-time is bits [CNT_W+DITH_W-1:DITH_W] and the fraction is bits [DITH_W-1:0].
- R6: The duty command is captured only on the clock that starts a frame. A change to `duty_i` inside a frame has no effect until the next frame.
- R7: A duty command of zero keeps the gate low on every clock.
- R8: When the coarse on-time is all ones, the gate is high on every clock and the fraction is ignored.
- R9: Asserting `rst_ni` low forces the gate and both strobes low at once. After release, both counters restart at zero, and the first frame runs with a duty of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_i | input | CNT_W+DITH_W | Duty command: coarse on-time above the fraction |
| gate_o | output | 1 | Gate pulse |
| period_start_o | output | 1 | Strobe on the first clock of each period |
| frame_start_o | output | 1 | Strobe on the first clock of each dither frame |

## Verification
A fault in the period counter shows within one period as a strobe spacing other than `2^CNT_W`, or as on-time counts that do not match the coarse value. A fault in the frame counter or the bit-reversal shows within one frame, because stretched periods land in the wrong slots or the number of stretched periods differs from the fraction. A fault in the capture point shows within two frames: either a mid-frame change to `duty_i` alters the remaining periods, or a new command starts in the wrong frame. All 2^(CNT_W+DITH_W) commands of the default configuration are swept, and every period of the measured frame is checked clock by clock.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // upper bound kept small so the bit-reversal and frame counter stay narrow
  localparam int unsigned DPWM_MAX_DITH_W = 8;

  function automatic int unsigned dpwm_len(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DITH_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DITH_W-1:0] frm_o,
  output logic              frame_end_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [DITH_W-1:0] FRM_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [DITH_W-1:0] frm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) frm_q <= frm_q + 1'b1;
    end
  end

  assign cnt_o       = cnt_q;
  assign frm_o       = frm_q;
  assign frame_end_o = (cnt_q == CNT_MAX) && (frm_q == FRM_MAX);

  // R2
  frame_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_MAX) |=> $stable(frm_q));
endmodule

// File: rtl/dpwm_dither_sel.sv
module dpwm_dither_sel #(
  parameter int unsigned DITH_W = 2
) (
  input  logic [DITH_W-1:0] frm_i,
  input  logic [DITH_W-1:0] frac_i,
  output logic              ext_o
);
  logic [DITH_W-1:0] frm_rev;

  // bit-reversed slot index spreads stretched periods evenly over the frame
  for (genvar i = 0; i < DITH_W; i++) begin : g_rev
    assign frm_rev[i] = frm_i[DITH_W-1-i];
  end

  assign ext_o = (frm_rev < frac_i);
endmodule

// File: rtl/dpwm_edge.sv
module dpwm_edge #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             frm_zero_i,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic             ext_i,
  output logic             gate_o,
  output logic             period_start_o,
  output logic             frame_start_o
);
  logic             full;
  logic [CNT_W:0]   on_len;
  logic             gate_d;
  logic             gate_q, pstart_q, fstart_q;

  assign full   = &coarse_i;
  assign on_len = {1'b0, coarse_i} + {{CNT_W{1'b0}}, ext_i};
  assign gate_d = full || ({1'b0, cnt_i} < on_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= 1'b0;
      pstart_q <= 1'b0;
      fstart_q <= 1'b0;
    end else begin
      gate_q   <= gate_d;
      pstart_q <= (cnt_i == '0);
      fstart_q <= (cnt_i == '0) && frm_zero_i;
    end
  end

  assign gate_o         = gate_q;
  assign period_start_o = pstart_q;
  assign frame_start_o  = fstart_q;

  // R3
  rose_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> period_start_o);
  // R2
  strobe_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> period_start_o);
  // R1
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DITH_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W+DITH_W-1:0] duty_i,
  output logic                    gate_o,
  output logic                    period_start_o,
  output logic                    frame_start_o
);
  localparam int unsigned DUTY_W = CNT_W + DITH_W;

  initial begin
    if (DITH_W < 1 || DITH_W > DPWM_MAX_DITH_W || CNT_W < 2)
      $error("dpwm_dither: unsupported width");
  end

  logic [CNT_W-1:0]  cnt;
  logic [DITH_W-1:0] frm;
  logic              frame_end;
  logic [DUTY_W-1:0] duty_q;
  logic              ext;

  dpwm_timebase #(.CNT_W(CNT_W), .DITH_W(DITH_W)) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_o       (cnt),
    .frm_o       (frm),
    .frame_end_o (frame_end)
  );

  // command held for a whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        duty_q <= '0;
    else if (frame_end) duty_q <= duty_i;
  end

  dpwm_dither_sel #(.DITH_W(DITH_W)) u_dither_sel (
    .frm_i  (frm),
    .frac_i (duty_q[DITH_W-1:0]),
    .ext_o  (ext)
  );

  dpwm_edge #(.CNT_W(CNT_W)) u_edge (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cnt_i          (cnt),
    .frm_zero_i     (frm == '0),
    .coarse_i       (duty_q[DUTY_W-1:DITH_W]),
    .ext_i          (ext),
    .gate_o         (gate_o),
    .period_start_o (period_start_o),
    .frame_start_o  (frame_start_o)
  );

  // R6
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(duty_q));
endmodule

// File: tb/dpwm_dither_bench.sv
module dpwm_dither_bench;
  localparam int CNT_W  = 4;
  localparam int DITH_W = 2;
  localparam int PER    = 1 << CNT_W;
  localparam int NFRM   = 1 << DITH_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W+DITH_W-1:0] duty_i = '0;
  logic gate_o, period_start_o, frame_start_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dpwm_dither #(.CNT_W(CNT_W), .DITH_W(DITH_W)) u_dpwm_dither (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty_i),
    .gate_o(gate_o), .period_start_o(period_start_o), .frame_start_o(frame_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    @(negedge clk_i);
    while (!frame_start_o) @(negedge clk_i);
  endtask

  function automatic int rev2(input int p);
    return ((p & 1) << 1) | ((p >> 1) & 1);
  endfunction

  // Entered at the negedge where frame_start_o is high; returns at the next frame start.
  task automatic measure(input int d, input int chg_at, input int chg_val, input string tag);
    int coarse = d >> DITH_W;
    int frac = d & (NFRM - 1);
    int pbad = 0;
    int fbad = 0;
    for (int p = 0; p < NFRM; p++) begin
      int hi, cnt_hi, bad;
      bit full, ext;
      string req;
      full = (coarse == PER - 1);
      ext = (rev2(p) < frac);
      hi = full ? PER : coarse + (ext ? 1 : 0);
      cnt_hi = 0;
      bad = 0;
      for (int k = 0; k < PER; k++) begin
        bit exp_g;
        if (p * PER + k == chg_at) duty_i = chg_val[CNT_W+DITH_W-1:0];
        exp_g = (k < hi);
        if (gate_o) cnt_hi++;
        if (gate_o !== exp_g) bad++;
        if (period_start_o !== (k == 0)) pbad++;
        if (frame_start_o !== (p == 0 && k == 0)) fbad++;
        @(negedge clk_i);
      end
      if (tag != "") req = tag;
      else if (full) req = "R8 full-scale";
      else if (d == 0) req = "R7 zero duty";
      else if (ext) req = "R4 R5 extended period";
      else req = "R3 R5 plain period";
      chk(bad == 0, $sformatf("%s duty=%0d period=%0d on-clocks", req, d, p), cnt_hi, hi);
    end
    chk(pbad == 0, $sformatf("R1 period strobe duty=%0d misplaced", d), pbad, 0);
    chk(fbad == 0, $sformatf("R2 frame strobe duty=%0d misplaced", d), fbad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // r9_ reset state
    chk(gate_o == 1'b0, "R9 gate in reset", gate_o, 0);
    chk(period_start_o == 1'b0 && frame_start_o == 1'b0, "R9 strobes in reset",
        period_start_o + frame_start_o, 0);
    duty_i = 6'd40;
    rst_ni = 1'b1;
    wait_frame();
    measure(0, -1, 0, "R9 first frame after reset");

    for (int d = 0; d < (1 << (CNT_W + DITH_W)); d++) begin
      duty_i = d[CNT_W+DITH_W-1:0];
      wait_frame();
      wait_frame();
      measure(d, -1, 0, "");
    end

    // R6: mid-frame change ignored, applied from the next frame
    duty_i = 6'd9;
    wait_frame();
    wait_frame();
    measure(9, 20, 63, "R6 mid-frame change ignored");
    measure(63, -1, 0, "R6 change applied next frame");

    // R9: asynchronous assertion mid-pulse
    duty_i = 6'd30;
    wait_frame();
    wait_frame();
    repeat (2) @(negedge clk_i);
    chk(gate_o == 1'b1, "R3 gate high before reset", gate_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(gate_o == 1'b0, "R9 async reset clears gate", gate_o, 0);
    chk(period_start_o == 1'b0, "R9 async reset clears strobe", period_start_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule